// File: doc/BRIEF.md
# Stop Mode Wake Controller

This block manages the low-power stop state of a small processor core. When the core issues a stop request and the clock-control wakeup bit is clear, the block enters a stopped state. In that state it drops the oscillator enable and the core clock enable. Register and memory contents are kept because the block never clears them. It touches no core state at all.

Two events end the stop state. An asynchronous hardware reset returns the block to normal running at once. An external interrupt whose own enable bit is set starts a stabilization phase. The interrupt lines are resynchronized onto a clock that keeps running while the core is stopped.

The stabilization phase waits for the oscillator to settle. An interval counter runs from zero to overflow, advanced through a prescaler whose divide ratio is captured when stop is entered. After overflow, a short release window keeps the core clock gated for the required no-operation slots. The block then hands control back to the core with a one-cycle pulse. That pulse is a vector request when the master interrupt flag is set, and a plain resume pulse when the flag is clear.

Top module: `stop_wake_unit`

## Requirements
- R1: Asynchronous reset (rstN low) forces wakeState to RUN (2'b00), oscEn and coreClkEn to 1, and vectorReq and resumeReq to 0. This applies from every state, including STOPPED and STABILIZING.
- R2: In RUN, stopReq high with wakeCtlBit 0 and no enabled interrupt pending moves wakeState to STOPPED (2'b01) at the next edge. In STOPPED both oscEn and coreClkEn are 0.
- R3: In RUN, stopReq with wakeCtlBit 1 has no effect, and wakeState stays RUN.
- R4: In STOPPED, an interrupt line whose irqEnable bit is 0 is ignored. A line whose irqEnable bit is 1 moves wakeState to STABILIZING (2'b10) on the third rising edge that samples it high, because it passes through a two-stage synchronizer.
- R5: STABILIZING lasts exactly 2^CNT_W * 2^sel cycles. Here sel is the prescSel value sampled on the stop-entry edge, and later changes to prescSel are ignored. oscEn is 1 and coreClkEn is 0 throughout.
- R6: After stabilization the block enters RELEASE (2'b11) for exactly NOP_SLOTS cycles, with coreClkEn held at 0.
- R7: Leaving RELEASE returns wakeState to RUN. In that first RUN cycle the block gives a one-cycle vectorReq if masterIe is 1, or a one-cycle resumeReq if masterIe is 0. The two pulses are never high together.
- R8: If an enabled interrupt is already pending (synchronized) when an accepted stop request arrives, STOPPED is skipped and wakeState goes straight to RELEASE.
- R9: stopReq is ignored in every state other than RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running stabilization clock, never gated by this block |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| stopReq | input | 1 | Core executes the stop instruction (one-cycle strobe) |
| wakeCtlBit | input | 1 | Wakeup bit of the clock control register; 1 blocks stop |
| prescSel | input | SEL_W | Prescaler divide select, divide by 2^prescSel |
| extIrq | input | NUM_IRQ | Raw asynchronous external interrupt requests |
| irqEnable | input | NUM_IRQ | Per-line interrupt enable bits |
| masterIe | input | 1 | Master interrupt enable flag of the core |
| oscEn | output | 1 | Oscillator enable, low only while stopped |
| coreClkEn | output | 1 | Core clock enable, high only in RUN |
| vectorReq | output | 1 | One-cycle request to vector to the interrupt handler |
| resumeReq | output | 1 | One-cycle request to resume at the next instruction |
| wakeState | output | 2 | Current state: RUN 00, STOPPED 01, STABILIZING 10, RELEASE 11 |

## Verification
The bench builds the block with NUM_IRQ=3, NOP_SLOTS=3, CNT_W=8 and SEL_W=2. The full 8-bit overflow stays in place, so every divide ratio from 1 to 8 can be run to completion: the longest wake sequence is 2048 cycles. A release window of three slots makes the slot count differ from the two-stage synchronizer delay, so an off-by-one in either one shows up on its own. With three interrupt lines, enabled and disabled requests can be raised at the same time while the block is stopped.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN       = 2'b00,
    ST_STOPPED   = 2'b01,
    ST_STABILIZE = 2'b10,
    ST_RELEASE   = 2'b11
  } wakeState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic captureSel;    // latch prescaler select at stop entry
    logic startStab;     // clear prescaler and interval counter
    logic stabRun;       // advance prescaler and interval counter
    logic startRelease;  // clear the release slot counter
    logic slotRun;       // advance the release slot counter
    logic fire;          // hand control back to the core
  } ctlStrobes_t;

endpackage

// File: rtl/stop_wake_sync.sv
module stop_wake_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/stop_wake_datapath.sv
module stop_wake_datapath
  import stop_wake_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int CNT_W     = 8,
  parameter int SEL_W     = 2,
  parameter int NOP_SLOTS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic               masterIe,
  input  logic [NUM_IRQ-1:0] irqSynced,
  input  logic [NUM_IRQ-1:0] irqEnable,
  output logic               pending,
  output logic               stabDone,
  output logic               slotsDone,
  output logic               vectorReq,
  output logic               resumeReq
);

  localparam int PRE_W  = (1 << SEL_W) - 1;
  localparam int SLOT_W = (NOP_SLOTS > 1) ? $clog2(NOP_SLOTS) : 1;

  logic [SEL_W-1:0]  selHeld;
  logic [PRE_W-1:0]  presc;
  logic [PRE_W-1:0]  divM1;
  logic [CNT_W-1:0]  intCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              presTick;

  assign pending = |(irqSynced & irqEnable);

  // divide ratio latched when stop is accepted, frozen afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   selHeld <= '0;
    else if (strobes.captureSel) selHeld <= prescSel;
  end

  always_comb divM1 = PRE_W'((32'd1 << selHeld) - 32'd1);
  assign presTick = (presc == divM1);

  // prescaler and interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc  <= '0;
      intCnt <= '0;
    end else if (strobes.startStab) begin
      presc  <= '0;
      intCnt <= '0;
    end else if (strobes.stabRun) begin
      if (presTick) begin
        presc  <= '0;
        intCnt <= intCnt + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  assign stabDone = presTick && (intCnt == {CNT_W{1'b1}});

  // release slot counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          slotCnt <= '0;
    else if (strobes.startRelease)      slotCnt <= '0;
    else if (strobes.slotRun && !slotsDone) slotCnt <= slotCnt + 1'b1;
  end

  assign slotsDone = (slotCnt == SLOT_W'(NOP_SLOTS - 1));

  // handback pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vectorReq <= 1'b0;
      resumeReq <= 1'b0;
    end else begin
      vectorReq <= strobes.fire && masterIe;
      resumeReq <= strobes.fire && !masterIe;
    end
  end

  p_sel_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stabRun |-> $stable(selHeld));

  p_cnt_rises_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stabRun && !stabDone) |=> (intCnt >= $past(intCnt)));

  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(vectorReq && resumeReq));

  p_vec_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vectorReq || resumeReq) |=> !(vectorReq || resumeReq));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        wakeCtlBit,
  input  logic        pending,
  input  logic        stabDone,
  input  logic        slotsDone,
  output ctlStrobes_t strobes,
  output logic        oscEn,
  output logic        coreClkEn,
  output logic [1:0]  wakeState
);

  wakeState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_RUN: begin
        if (stopReq && !wakeCtlBit) begin
          strobes.captureSel = 1'b1;
          if (pending) begin
            stateNext            = ST_RELEASE;
            strobes.startRelease = 1'b1;
          end else begin
            stateNext = ST_STOPPED;
          end
        end
      end
      ST_STOPPED: begin
        if (pending) begin
          stateNext         = ST_STABILIZE;
          strobes.startStab = 1'b1;
        end
      end
      ST_STABILIZE: begin
        strobes.stabRun = 1'b1;
        if (stabDone) begin
          stateNext            = ST_RELEASE;
          strobes.startRelease = 1'b1;
        end
      end
      ST_RELEASE: begin
        strobes.slotRun = 1'b1;
        if (slotsDone) begin
          stateNext    = ST_RUN;
          strobes.fire = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign oscEn     = (state != ST_STOPPED);
  assign coreClkEn = (state == ST_RUN);
  assign wakeState = state;

  p_wake_bit_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq && wakeCtlBit) |=> (wakeState == 2'b00));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPED && !pending) |=> (wakeState == 2'b01 && !oscEn));

  p_stab_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STABILIZE && !stabDone) |=> (wakeState == 2'b10 && !coreClkEn));

  p_release_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STABILIZE && stabDone) |=> (wakeState == 2'b11 && !coreClkEn));

  p_skip_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq && !wakeCtlBit && pending) |=> (wakeState == 2'b11));

endmodule

// File: rtl/stop_wake_unit.sv
module stop_wake_unit
  import stop_wake_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 2,
  parameter int NOP_SLOTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stopReq,
  input  logic               wakeCtlBit,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic [NUM_IRQ-1:0] extIrq,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic               masterIe,
  output logic               oscEn,
  output logic               coreClkEn,
  output logic               vectorReq,
  output logic               resumeReq,
  output logic [1:0]         wakeState
);

  ctlStrobes_t        strobes;
  logic [NUM_IRQ-1:0] irqSynced;
  logic               pending;
  logic               stabDone;
  logic               slotsDone;

  stop_wake_sync #(
    .WIDTH  (NUM_IRQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extIrq),
    .syncOut (irqSynced)
  );

  stop_wake_datapath #(
    .NUM_IRQ   (NUM_IRQ),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .NOP_SLOTS (NOP_SLOTS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .prescSel  (prescSel),
    .masterIe  (masterIe),
    .irqSynced (irqSynced),
    .irqEnable (irqEnable),
    .pending   (pending),
    .stabDone  (stabDone),
    .slotsDone (slotsDone),
    .vectorReq (vectorReq),
    .resumeReq (resumeReq)
  );

  stop_wake_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .wakeCtlBit (wakeCtlBit),
    .pending    (pending),
    .stabDone   (stabDone),
    .slotsDone  (slotsDone),
    .strobes    (strobes),
    .oscEn      (oscEn),
    .coreClkEn  (coreClkEn),
    .wakeState  (wakeState)
  );

endmodule

// File: tb/test_stop_wake_unit.sv
`timescale 1ns/1ps
module test_stop_wake_unit;

  localparam int NIRQ = 3;
  localparam int SELW = 2;
  localparam int NOPS = 3;
  localparam int CW   = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            stopReq = 1'b0;
  logic            wakeCtlBit = 1'b0;
  logic            masterIe = 1'b0;
  logic [SELW-1:0] prescSel = '0;
  logic [NIRQ-1:0] extIrq = '0;
  logic [NIRQ-1:0] irqEnable = '0;
  logic            oscEn, coreClkEn, vectorReq, resumeReq;
  logic [1:0]      wakeState;

  int  vecCnt = 0;
  int  badCnt = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  stop_wake_unit #(
    .NUM_IRQ   (NIRQ),
    .CNT_W     (CW),
    .SEL_W     (SELW),
    .NOP_SLOTS (NOPS)
  ) i_stop_wake_unit (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .wakeCtlBit (wakeCtlBit),
    .prescSel   (prescSel),
    .extIrq     (extIrq),
    .irqEnable  (irqEnable),
    .masterIe   (masterIe),
    .oscEn      (oscEn),
    .coreClkEn  (coreClkEn),
    .vectorReq  (vectorReq),
    .resumeReq  (resumeReq),
    .wakeState  (wakeState)
  );

  // behavioural reference: 0 run, 1 stopped, 2 stabilizing, 3 release
  int              mState = 0;
  int              mWait = 0;
  int              mSlots = 0;
  int              mDiv = 1;
  bit              mVec = 1'b0;
  bit              mRes = 1'b0;
  logic [NIRQ-1:0] mHist [$];

  always @(posedge clk) begin
    bit pend;
    if (!rstN) begin
      mState = 0; mWait = 0; mSlots = 0; mVec = 0; mRes = 0;
      mHist = {};
    end else begin
      pend = (mHist.size() >= 2) ? |(mHist[mHist.size()-2] & irqEnable) : 1'b0;
      mHist.push_back(extIrq);
      if (mHist.size() > 2) void'(mHist.pop_front());
      mVec = 0; mRes = 0;
      case (mState)
        0: if (stopReq && !wakeCtlBit) begin
             mDiv   = 1 << prescSel;
             mSlots = 0;
             mState = pend ? 3 : 1;
           end
        1: if (pend) begin
             mState = 2;
             mWait  = (1 << CW) * mDiv;
           end
        2: begin
             mWait--;
             if (mWait == 0) begin mState = 3; mSlots = 0; end
           end
        default: begin
             mSlots++;
             if (mSlots == NOPS) begin
               mState = 0;
               if (masterIe) mVec = 1; else mRes = 1;
             end
           end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      badCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string stTag(input int s);
    case (s)
      0: return "R3 state(run)";
      1: return "R4 state(stopped)";
      2: return "R5 state(stabilizing)";
      default: return "R6 state(release)";
    endcase
  endfunction

  task automatic compareAll();
    chk(stTag(mState), int'(wakeState), mState);
    chk("R2 oscEn", int'(oscEn), int'(mState != 1));
    chk("R6 coreClkEn", int'(coreClkEn), int'(mState == 0));
    chk("R7 vectorReq", int'(vectorReq), int'(mVec));
    chk("R7 resumeReq", int'(resumeReq), int'(mRes));
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic runWake(input int sel, input bit mie);
    int stabLen;
    int relLen;
    stabLen = 0;
    relLen  = 0;
    prescSel  = sel[SELW-1:0];
    masterIe  = mie;
    irqEnable = 3'b100;
    stopReq = 1'b1; cyc(1); stopReq = 1'b0;
    chk("R2 stop entered", int'(wakeState), 1);
    chk("R2 clocks gated", int'({oscEn, coreClkEn}), 0);
    prescSel = ~prescSel;                        // R5: must not matter
    stopReq = 1'b1; cyc(1); stopReq = 1'b0;
    chk("R9 stop request while stopped", int'(wakeState), 1);
    extIrq = 3'b011; cyc(8);
    chk("R4 disabled interrupts ignored", int'(wakeState), 1);
    extIrq = 3'b111; cyc(2);
    chk("R4 synchronizer delay", int'(wakeState), 1);
    cyc(1);
    chk("R4 wake on enabled interrupt", int'(wakeState), 2);
    extIrq = '0;
    while (wakeState == 2'b10 && stabLen < 5000) begin
      stabLen++;
      chk("R5 clocks during stabilization", int'({oscEn, coreClkEn}), 2);
      cyc(1);
    end
    chk("R5 stabilization length", stabLen, (1 << CW) << sel);
    chk("R6 release entered", int'(wakeState), 3);
    while (wakeState == 2'b11 && relLen < 20) begin
      relLen++;
      chk("R6 core clock held low", int'(coreClkEn), 0);
      cyc(1);
    end
    chk("R6 release slots", relLen, NOPS);
    chk(mie ? "R7 vector pulse" : "R7 resume pulse",
        int'({vectorReq, resumeReq}), mie ? 2 : 1);
    cyc(1);
    chk("R7 single pulse", int'({vectorReq, resumeReq}), 0);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    chk("R1 reset state", int'(wakeState), 0);
    chk("R1 reset clocks", int'({oscEn, coreClkEn}), 3);
    chk("R1 reset pulses", int'({vectorReq, resumeReq}), 0);

    wakeCtlBit = 1'b1; stopReq = 1'b1; cyc(1);
    stopReq = 1'b0; wakeCtlBit = 1'b0;
    chk("R3 wake bit blocks stop", int'(wakeState), 0);
    cyc(2);

    runWake(0, 1'b1);
    runWake(2, 1'b0);
    runWake(3, 1'b1);
    runWake(1, 1'b0);

    // R8: enabled request already pending at the stop request
    masterIe = 1'b1; irqEnable = 3'b010; extIrq = 3'b010; cyc(3);
    stopReq = 1'b1; cyc(1); stopReq = 1'b0;
    chk("R8 stop skipped to release", int'(wakeState), 3);
    cyc(NOPS + 2);
    extIrq = '0; cyc(3);

    // R1: reset out of STOPPED
    irqEnable = '0;
    stopReq = 1'b1; cyc(1); stopReq = 1'b0; cyc(3);
    chk("R4 held in stop", int'(wakeState), 1);
    rstN = 1'b0; cyc(1);
    chk("R1 reset exits stop", int'(wakeState), 0);
    chk("R1 clocks after reset", int'({oscEn, coreClkEn}), 3);
    rstN = 1'b1; cyc(2);

    // R1: reset out of STABILIZING
    irqEnable = 3'b001; prescSel = 2'd3;
    stopReq = 1'b1; cyc(1); stopReq = 1'b0; cyc(2);
    extIrq = 3'b001; cyc(10);
    chk("R5 stabilizing", int'(wakeState), 2);
    rstN = 1'b0; extIrq = '0; cyc(1);
    chk("R1 reset exits stabilization", int'(wakeState), 0);
    rstN = 1'b1; cyc(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      badCnt++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end

endmodule